// File: doc/BRIEF.md
# Triple-Clocked Majority-Voted Register Pipeline

This block is a register pipeline of configurable depth and width, hardened against single-event upsets by keeping three full copies of every register. Each copy runs on its own clock and its own reset, so a glitch on one clock or reset net can disturb only one copy. After every register stage, each copy has its own bitwise majority voter. The voter reads the same stage of all three copies, and its result loads the next stage of that copy. An upset bit in any one register is therefore outvoted and overwritten at the following clock edge. Errors cannot pile up along the chain.

A single data input feeds the first stage of all three copies. Each copy drives its own output from its own voter after the last stage, so a later triplicated consumer keeps the separation. A per-stage flag shows when the three copies of that stage disagree. The flag is for observation only and never alters the data.

Top module: `tmr_pipe`

## Requirements
- R1: While all three resets are high, every register of every copy is zero, so `out_a`, `out_b`, `out_c` and `stage_err` all read zero.
- R2: With no upset, each output equals the value of `din` captured DEPTH rising clock edges earlier.
- R3: The three outputs carry the same value at all times outside a full reset.
- R4: A single flipped bit in any one register of any one copy never appears on any output.
- R5: Bit k of `stage_err` is 1 exactly when the three copies of stage k (stage 0 holds the newest data) differ in at least one bit. After one upset in stage k, `stage_err` equals one-hot bit k.
- R6: An upset is scrubbed at the next clock edge of the affected copy, after which `stage_err` returns to zero.
- R7: Raising only one copy's reset clears only that copy. The outputs stay correct, and while the other two copies hold all-ones data, every bit of `stage_err` is 1.
- R8: After a single copy's reset is released, that copy is fully restored by its first clock edge, and `stage_err` reads zero.
- R9: Voting is bitwise. Two copies upset in different bits of the same stage are still corrected, and the outputs stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of copy A |
| rst_a | input | 1 | Asynchronous active-high reset of copy A |
| clk_b | input | 1 | Clock of copy B |
| rst_b | input | 1 | Asynchronous active-high reset of copy B |
| clk_c | input | 1 | Clock of copy C |
| rst_c | input | 1 | Asynchronous active-high reset of copy C |
| din | input | WIDTH | Data loaded into stage 0 of all copies |
| out_a | output | WIDTH | Voted last-stage value for copy A |
| out_b | output | WIDTH | Voted last-stage value for copy B |
| out_c | output | WIDTH | Voted last-stage value for copy C |
| stage_err | output | DEPTH | Per-stage disagreement flags, bit k for stage k |

## Verification
The assertions check four properties on every edge:
- the outputs are zero during a full reset;
- the three outputs agree;
- copy A's output matches a delayed copy of `din`;
- any raised disagreement flag is cleared one edge later, and a copy whose reset was just released is back in agreement after one edge.

Only the bench's scenarios can show upset correction and the exact one-hot flag pattern. It flips chosen register bits through a force hook, one stage and one copy at a time, and also two bits in different copies. It also holds each copy's reset on its own while all-ones data flows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Number of redundant copies of the data path.
    localparam int unsigned TMR_COPIES = 3;

    // Two-of-three majority of a single bit.
    function automatic logic maj_bit(input logic a, input logic b, input logic c);
        return (a & b) | (b & c) | (a & c);
    endfunction

    // True when the three bits are not all equal.
    function automatic logic diff_bit(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] y
);
    import tmr_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb y[i] = maj_bit(a[i], b[i], c[i]);
    end

endmodule

// File: rtl/tmr_diff.sv
module tmr_diff #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic             flag
);
    import tmr_pkg::*;

    logic [WIDTH-1:0] bit_diff;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb bit_diff[i] = diff_bit(a[i], b[i], c[i]);
    end

    always_comb flag = |bit_diff;

endmodule

// File: rtl/tmr_lane.sv
module tmr_lane #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [WIDTH-1:0]            din,
    input  logic [DEPTH-2:0][WIDTH-1:0] fb,
    output logic [DEPTH-1:0][WIDTH-1:0] stg
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] stg;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = din;
        for (int k = 1; k < int'(DEPTH); k++) begin
            st_d.stg[k] = fb[k-1];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stg = st_q.stg;

endmodule

// File: rtl/tmr_pipe.sv
module tmr_pipe #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             clk_c,
    input  logic             rst_c,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] out_a,
    output logic [WIDTH-1:0] out_b,
    output logic [WIDTH-1:0] out_c,
    output logic [DEPTH-1:0] stage_err
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] stg_a, stg_b, stg_c;
    logic [DEPTH-1:0][WIDTH-1:0] vote_a, vote_b, vote_c;

    tmr_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane_a (
        .clk(clk_a), .rst(rst_a), .din(din), .fb(vote_a[DEPTH-2:0]), .stg(stg_a)
    );
    tmr_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane_b (
        .clk(clk_b), .rst(rst_b), .din(din), .fb(vote_b[DEPTH-2:0]), .stg(stg_b)
    );
    tmr_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane_c (
        .clk(clk_c), .rst(rst_c), .din(din), .fb(vote_c[DEPTH-2:0]), .stg(stg_c)
    );

    // One voter per copy per stage, plus one disagreement detector per stage.
    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        tmr_voter #(.WIDTH(WIDTH)) u_vote_a (
            .a(stg_a[k]), .b(stg_b[k]), .c(stg_c[k]), .y(vote_a[k])
        );
        tmr_voter #(.WIDTH(WIDTH)) u_vote_b (
            .a(stg_a[k]), .b(stg_b[k]), .c(stg_c[k]), .y(vote_b[k])
        );
        tmr_voter #(.WIDTH(WIDTH)) u_vote_c (
            .a(stg_a[k]), .b(stg_b[k]), .c(stg_c[k]), .y(vote_c[k])
        );
        tmr_diff #(.WIDTH(WIDTH)) u_diff (
            .a(stg_a[k]), .b(stg_b[k]), .c(stg_c[k]), .flag(stage_err[k])
        );
    end

    assign out_a = vote_a[LAST];
    assign out_b = vote_b[LAST];
    assign out_c = vote_c[LAST];

endmodule

// File: rtl/tmr_pipe_chk.sv
module tmr_pipe_chk #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input logic             clk_a,
    input logic             rst_a,
    input logic             rst_b,
    input logic             rst_c,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] out_a,
    input logic [WIDTH-1:0] out_b,
    input logic [WIDTH-1:0] out_c,
    input logic [DEPTH-1:0] stage_err
);
    logic rst_all;
    logic rst_any;
    logic [DEPTH-1:0][WIDTH-1:0] hist_q;

    assign rst_all = rst_a & rst_b & rst_c;
    assign rst_any = rst_a | rst_b | rst_c;

    // Delay line of din, used as the latency reference.
    always_ff @(posedge clk_a or posedge rst_all) begin
        if (rst_all) hist_q <= '0;
        else         hist_q <= {hist_q[DEPTH-2:0], din};
    end

    a_r1_reset_clear: assert property (@(posedge clk_a)
        rst_all |-> (out_a == '0 && out_b == '0 && out_c == '0 && stage_err == '0));

    a_r3_outputs_agree: assert property (@(posedge clk_a) disable iff (rst_all)
        (out_a == out_b) && (out_b == out_c));

    a_r2_latency: assert property (@(posedge clk_a) disable iff (rst_all)
        out_a == hist_q[DEPTH-1]);

    a_r6_scrub_next_edge: assert property (@(posedge clk_a) disable iff (rst_any)
        (stage_err != '0) |=> (stage_err == '0));

    a_r8_restore_a: assert property (@(posedge clk_a) disable iff (rst_b || rst_c)
        $fell(rst_a) |=> (stage_err == '0));

endmodule

bind tmr_pipe tmr_pipe_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk_a(clk_a), .rst_a(rst_a), .rst_b(rst_b), .rst_c(rst_c), .din(din),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .stage_err(stage_err)
);

// File: tb/tmr_pipe_test.sv
module tmr_pipe_test;
    localparam int W = 8;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_a = 1'b1, rst_b = 1'b1, rst_c = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] out_a, out_b, out_c;
    logic [D-1:0] stage_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] hist [D];

    always #5 clk = ~clk;

    tmr_pipe #(.WIDTH(W), .DEPTH(D)) uut (
        .clk_a(clk), .rst_a(rst_a), .clk_b(clk), .rst_b(rst_b),
        .clk_c(clk), .rst_c(rst_c), .din(din),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .stage_err(stage_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_out();
        return hist[D-1];
    endfunction

    // Entered at a falling edge: check outputs, apply new data, advance one cycle.
    task automatic tick(input logic [W-1:0] d, input string req);
        check({req, " out_a"}, 32'(out_a), 32'(ref_out()));
        check("R3 out_b", 32'(out_b), 32'(out_a));
        check("R3 out_c", 32'(out_c), 32'(out_a));
        for (int i = D - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = d;
        din = d;
        @(negedge clk);
    endtask

    task automatic clear_hist();
        for (int i = 0; i < D; i++) hist[i] = '0;
    endtask

    // Flip one bit of one register in one copy.
    task automatic inject(input int copy, input int stage, input int bitn);
        logic [D*W-1:0] v;
        case (copy)
            0: begin
                v = uut.u_lane_a.st_q;
                v[stage*W+bitn] = ~v[stage*W+bitn];
                force uut.u_lane_a.st_q = v;
                #1 release uut.u_lane_a.st_q;
            end
            1: begin
                v = uut.u_lane_b.st_q;
                v[stage*W+bitn] = ~v[stage*W+bitn];
                force uut.u_lane_b.st_q = v;
                #1 release uut.u_lane_b.st_q;
            end
            default: begin
                v = uut.u_lane_c.st_q;
                v[stage*W+bitn] = ~v[stage*W+bitn];
                force uut.u_lane_c.st_q = v;
                #1 release uut.u_lane_c.st_q;
            end
        endcase
    endtask

    task automatic set_rst(input int copy, input logic v);
        case (copy)
            0:       rst_a = v;
            1:       rst_b = v;
            default: rst_c = v;
        endcase
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        clear_hist();
        repeat (3) @(negedge clk);
        // R1: full reset state
        check("R1 out_a", 32'(out_a), 0);
        check("R1 out_b", 32'(out_b), 0);
        check("R1 out_c", 32'(out_c), 0);
        check("R1 stage_err", 32'(stage_err), 0);
        rst_a = 1'b0; rst_b = 1'b0; rst_c = 1'b0;

        // R2: random traffic and directed patterns
        for (int i = 0; i < 60; i++) tick(W'($urandom), "R2");
        tick('1, "R2"); tick('0, "R2"); tick(W'(8'h55), "R2"); tick(W'(8'hAA), "R2");
        for (int i = 0; i < D; i++) tick(W'($urandom), "R2");

        // R4/R5/R6: single upsets in every stage of every copy
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < D; k++) begin
                tick(W'($urandom), "R4");
                inject(c, k, int'($urandom % W));
                check("R5 one-hot flag", 32'(stage_err), 32'(1 << k));
                tick(W'($urandom), "R4");
                check("R6 scrubbed", 32'(stage_err), 0);
            end
        end

        // R9: two copies upset in different bits of the same stage
        for (int k = 0; k < D; k++) begin
            tick(W'($urandom), "R9");
            inject(0, k, 0);
            inject(2, k, W - 1);
            check("R9 flag", 32'(stage_err), 32'(1 << k));
            tick(W'($urandom), "R9");
            check("R9 scrubbed", 32'(stage_err), 0);
        end
        for (int i = 0; i < D; i++) tick(W'($urandom), "R9");

        // R7/R8: one copy reset at a time
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < D; i++) tick('1, "R7");
            set_rst(c, 1'b1);
            #1 check("R7 all stages differ", 32'(stage_err), 32'((1 << D) - 1));
            for (int i = 0; i < 3; i++) tick('1, "R7");
            set_rst(c, 1'b0);
            tick(W'($urandom), "R8");
            check("R8 restored", 32'(stage_err), 0);
            for (int i = 0; i < 4; i++) tick(W'($urandom), "R8");
        end

        // R1: full reset mid-stream
        rst_a = 1'b1; rst_b = 1'b1; rst_c = 1'b1;
        #1;
        check("R1 mid out_a", 32'(out_a), 0);
        check("R1 mid stage_err", 32'(stage_err), 0);
        clear_hist();
        @(negedge clk);
        rst_a = 1'b0; rst_b = 1'b0; rst_c = 1'b0;
        for (int i = 0; i < 20; i++) tick(W'($urandom), "R2");

        summary();
    end

endmodule